// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling

This block takes one asynchronous serial line and turns it into bytes. A clock divider makes a tick at sixteen times the bit rate. On each tick the block samples the synchronised line. It checks the start bit at its middle and takes each later bit as the majority of three neighbouring samples. It rebuilds a frame of 8 data bits, sent least significant bit first. An optional parity bit may follow the data, and one stop bit ends the frame. Each finished frame goes into a 16-entry receive queue together with two tags: one for a bad stop bit and one for a parity mismatch.

Software sees the oldest queue entry on a read port and removes it with a pop strobe. The framing and parity status bits always describe that oldest entry, not the history of the line.

A line held at space past a faulty frame counts as a break. The block raises a sticky break flag and writes nothing more to the queue until the line has returned to mark and a new frame has arrived. A sticky overrun flag marks bytes lost because the queue was full. Software clears each sticky flag with a status read that sees the flag at 1, followed by a write of 0 to that flag.

Top module: `rxl_receiver`

## Requirements
- R1: After reset `rdy_o`, `frm_err_o`, `par_err_o`, `brk_o` and `ovr_o` are all 0.
- R2: A frame is a 0 start bit, then 8 data bits sent LSB first, then the parity bit when enabled, then one stop bit. One bit lasts 16 × `CLKS_PER_TICK` clocks. Received bytes appear on `rd_data_o` in arrival order.
- R3: With `par_en_i`=1 the parity bit is checked. With `par_odd_i`=0 the data bits plus the parity bit must hold an even number of ones; with `par_odd_i`=1 they must hold an odd number. A mismatch sets the entry's parity tag. With `par_en_i`=0 the tag is always 0.
- R4: A stop bit sampled as 0 sets the entry's framing tag.
- R5: `frm_err_o` and `par_err_o` show the tags of the head entry only. Both are 0 while the queue is empty, and both take the next entry's tags after a pop.
- R6: `rdy_o` is 1 exactly when the queue holds at least one entry. A `pop_i` pulse removes the head entry.
- R7: A break is a frame with a framing error after which the line is still 0 one bit time past the stop sample. A break sets `brk_o`, and the frame that caused it is stored as byte 0x00 with its framing tag set.
- R8: After a break, no entry is written while the line stays 0. Reception resumes with the first frame that starts after the line has returned to 1.
- R9: A `st_rd_i` pulse while `brk_o`=1 arms the break clear. The next `st_wr_i` with `st_wdata_i[0]`=0 then clears `brk_o`. Any write disarms the clear. A write without a prior armed read leaves `brk_o` unchanged.
- R10: A frame that arrives while 16 entries are held is discarded and sets the sticky `ovr_o`. `ovr_o` is cleared by the scheme of R9, using `st_wdata_i[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line (idle = 1) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| pop_i | input | 1 | Remove the head entry |
| st_rd_i | input | 1 | Status read strobe (arms sticky-flag clears) |
| st_wr_i | input | 1 | Status write strobe |
| st_wdata_i | input | 2 | Status write data: bit 0 is break, bit 1 is overrun |
| rd_data_o | output | 8 | Head entry data byte (0 when empty) |
| rdy_o | output | 1 | Queue not empty |
| frm_err_o | output | 1 | Framing tag of the head entry |
| par_err_o | output | 1 | Parity tag of the head entry |
| brk_o | output | 1 | Sticky break flag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
A byte enters the queue at the majority sample of its stop bit, which falls just before the middle of that bit. The queue is therefore never expected to have drained before the driver has sent the whole stop bit plus one idle bit. The break flag rises one bit time after the faulty stop sample, and each check of it waits at least two further bit times of low line. The sticky flags and the head-entry tags change on the clock edge that follows a strobe, so every check samples at the next falling edge. The monitor compares each head entry before it pulses the pop, and it looks at the following entry only after a full clock has passed.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic          fe;
    logic          pe;
    logic [DW-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_FEWAIT, S_BRK
  } rx_state_e;

  // majority vote of three line samples
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // 1 when data plus parity bit disagree with the chosen sense
  function automatic logic par_bad(input logic [DW-1:0] d, input logic pbit,
                                   input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction
endpackage

// File: rtl/rxl_tick.sv
module rxl_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LIM = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (cnt == LIM)  cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick_o = (cnt == LIM);
endmodule

// File: rtl/rxl_framer.sv
module rxl_framer
  import rxl_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      frm_vld_o,
  output rx_entry_t frm_o,
  output logic      brk_det_o,
  output logic      brk_hold_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [1:0]    sync;
  logic          rx_s;
  logic [2:0]    smp;
  rx_state_e     st;
  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [DW-1:0] shreg;
  logic          pbit;
  logic          bit_val;
  logic          bit_end;

  assign rx_s    = sync[1];
  assign bit_val = maj3(smp);
  assign bit_end = tick_i && (tcnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync      <= 2'b11;
      smp       <= 3'b111;
      st        <= S_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      frm_vld_o <= 1'b0;
      frm_o     <= '0;
      brk_det_o <= 1'b0;
    end else begin
      sync      <= {sync[0], rx_i};
      frm_vld_o <= 1'b0;
      brk_det_o <= 1'b0;
      if (tick_i) begin
        smp <= {smp[1:0], rx_s};
        unique case (st)
          S_IDLE: begin
            tcnt <= '0;
            if (!rx_s) begin
              st   <= S_START;
              tcnt <= CW'(1);
            end
          end
          S_START: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == MID) begin
              tcnt <= '0;
              bidx <= '0;
              st   <= rx_s ? S_IDLE : S_DATA;
            end
          end
          S_DATA: begin
            tcnt <= tcnt + 1'b1;
            if (bit_end) begin
              shreg <= {bit_val, shreg[DW-1:1]};
              bidx  <= bidx + 1'b1;
              if (bidx == 3'd7) st <= par_en_i ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            tcnt <= tcnt + 1'b1;
            if (bit_end) begin
              pbit <= bit_val;
              st   <= S_STOP;
            end
          end
          S_STOP: begin
            tcnt <= tcnt + 1'b1;
            if (bit_end) begin
              frm_vld_o  <= 1'b1;
              frm_o.data <= shreg;
              frm_o.fe   <= ~bit_val;
              frm_o.pe   <= par_en_i & par_bad(shreg, pbit, par_odd_i);
              st         <= bit_val ? S_IDLE : S_FEWAIT;
            end
          end
          S_FEWAIT: begin
            tcnt <= tcnt + 1'b1;
            if (rx_s) st <= S_IDLE;
            else if (tcnt == LAST) begin
              brk_det_o <= 1'b1;
              st        <= S_BRK;
            end
          end
          S_BRK: begin
            tcnt <= '0;
            if (rx_s) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign brk_hold_o = (st == S_BRK);

  // R2
  frm_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_o |=> !frm_vld_o);

  // R7
  brk_after_fe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_det_o |-> frm_o.fe);

  // R8
  brk_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_hold_o && !rx_s) |=> !frm_vld_o);
endmodule

// File: rtl/rxl_fifo.sv
module rxl_fifo
  import rxl_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  rx_entry_t wdata_i,
  input  logic      rd_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      full_o,
  output logic      drop_o
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = AW + 1;
  localparam logic [CNTW-1:0] FULLV = CNTW'(DEPTH);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;
  logic            do_wr, do_rd;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == FULLV);
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign drop_o  = wr_i && full_o;
  assign head_o  = mem[rp];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= nxt(wp);
      if (do_rd) rp <= nxt(rp);
      unique case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i) |=> full_o);

  // R6
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_o && !wr_i) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rxl_flags.sv
module rxl_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brk_set_i,
  input  logic       ovr_set_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic       brk_o,
  output logic       ovr_o
);
  logic brk_arm, ovr_arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_o   <= 1'b0;
      ovr_o   <= 1'b0;
      brk_arm <= 1'b0;
      ovr_arm <= 1'b0;
    end else begin
      if (brk_set_i)                            brk_o <= 1'b1;
      else if (wr_i && brk_arm && !wdata_i[0])  brk_o <= 1'b0;
      if (ovr_set_i)                            ovr_o <= 1'b1;
      else if (wr_i && ovr_arm && !wdata_i[1])  ovr_o <= 1'b0;

      if (wr_i)                brk_arm <= 1'b0;
      else if (rd_i && brk_o)  brk_arm <= 1'b1;
      if (wr_i)                ovr_arm <= 1'b0;
      else if (rd_i && ovr_o)  ovr_arm <= 1'b1;
    end
  end

  // R7
  brk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_set_i |=> brk_o);

  // R9
  brk_noarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && wr_i && !brk_arm) |=> brk_o);

  // R10
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set_i |=> ovr_o);
endmodule

// File: rtl/rxl_receiver.sv
module rxl_receiver
  import rxl_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVS           = 16,
  parameter int DEPTH         = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          pop_i,
  input  logic          st_rd_i,
  input  logic          st_wr_i,
  input  logic [1:0]    st_wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rdy_o,
  output logic          frm_err_o,
  output logic          par_err_o,
  output logic          brk_o,
  output logic          ovr_o
);
  logic      tick;
  logic      frm_vld;
  rx_entry_t frm;
  logic      brk_det;
  logic      brk_hold;
  rx_entry_t head;
  logic      q_empty, q_full, q_drop;

  rxl_tick #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  rxl_framer #(.OVS(OVS)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .rx_i       (rx_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .frm_vld_o  (frm_vld),
    .frm_o      (frm),
    .brk_det_o  (brk_det),
    .brk_hold_o (brk_hold)
  );

  rxl_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (frm_vld),
    .wdata_i (frm),
    .rd_i    (pop_i),
    .head_o  (head),
    .empty_o (q_empty),
    .full_o  (q_full),
    .drop_o  (q_drop)
  );

  rxl_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .brk_set_i (brk_det),
    .ovr_set_i (q_drop),
    .rd_i      (st_rd_i),
    .wr_i      (st_wr_i),
    .wdata_i   (st_wdata_i),
    .brk_o     (brk_o),
    .ovr_o     (ovr_o)
  );

  assign rdy_o     = !q_empty;
  assign rd_data_o = q_empty ? '0 : head.data;
  assign frm_err_o = !q_empty && head.fe;
  assign par_err_o = !q_empty && head.pe;

  // R8
  no_push_in_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(brk_hold) && brk_hold |-> !frm_vld);

  // R6
  rdy_after_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld && !q_full) |=> rdy_o);
endmodule

// File: tb/rxl_receiver_bench.sv
`timescale 1ns/1ps
module rxl_receiver_bench;
  localparam int CPT = 2;
  localparam int OVS = 16;
  localparam int BIT = CPT * OVS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic       pop = 1'b0;
  logic       st_rd = 1'b0, st_wr = 1'b0;
  logic [1:0] st_wdata = 2'b11;
  logic [7:0] rd_data;
  logic       rdy, frm_err, par_err, brk, ovr;

  int checks = 0;
  int fails  = 0;
  int mon_credit = -1;
  logic [9:0] expq[$];

  always #2 clk = ~clk;

  rxl_receiver #(.CLKS_PER_TICK(CPT), .OVS(OVS), .DEPTH(16)) u_rxl_receiver (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .par_en_i(par_en),
    .par_odd_i(par_odd), .pop_i(pop), .st_rd_i(st_rd), .st_wr_i(st_wr),
    .st_wdata_i(st_wdata), .rd_data_o(rd_data), .rdy_o(rdy),
    .frm_err_o(frm_err), .par_err_o(par_err), .brk_o(brk), .ovr_o(ovr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: push expected item, then drive the frame on the line
  task automatic send(input logic [7:0] d, input logic bad_par,
                      input logic stopv, input logic expect_it);
    logic pb;
    pb = (^d) ^ par_odd ^ bad_par;
    if (expect_it) expq.push_back({~stopv, par_en & bad_par, d});
    @(negedge clk);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (par_en) begin
      rx = pb;
      repeat (BIT) @(negedge clk);
    end
    rx = stopv;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (BIT) @(negedge clk);
    // R2: byte due by the end of stop bit plus one idle bit
    if (mon_credit < 0) chk("R2", "queue drained after frame", expq.size(), 0);
  endtask

  task automatic step_pop();
    mon_credit = 1;
    while (mon_credit != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic st_read();
    @(negedge clk); st_rd = 1'b1;
    @(negedge clk); st_rd = 1'b0;
  endtask

  task automatic st_write(input logic [1:0] v);
    @(negedge clk); st_wr = 1'b1; st_wdata = v;
    @(negedge clk); st_wr = 1'b0; st_wdata = 2'b11;
  endtask

  // monitor: compare head against scoreboard, then pop
  initial begin
    forever begin
      @(negedge clk);
      if (pop) pop = 1'b0;
      else if (rst_n && rdy && mon_credit != 0) begin
        if (expq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 unexpected entry actual=%0h expected=none", rd_data);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          chk("R2", "data", rd_data, e[7:0]);
          chk("R4", "framing tag", frm_err, e[9]);
          chk("R3", "parity tag", par_err, e[8]);
        end
        pop = 1'b1;
        if (mon_credit > 0) mon_credit--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "rdy", rdy, 0);
    chk("R1", "frm_err", frm_err, 0);
    chk("R1", "par_err", par_err, 0);
    chk("R1", "brk", brk, 0);
    chk("R1", "ovr", ovr, 0);

    // R2 plain bytes
    send(8'h55, 0, 1, 1);
    send(8'hA3, 0, 1, 1);
    send(8'hFF, 0, 1, 1);
    send(8'h00, 0, 1, 1);

    // R3 parity both senses
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h96, 0, 1, 1);
    send(8'h96, 1, 1, 1);
    par_odd = 1'b1;
    send(8'h07, 0, 1, 1);
    send(8'h07, 1, 1, 1);

    // R4 framing error, line returns to mark: no break
    par_en = 1'b0;
    send(8'h5A, 0, 0, 1);
    chk("R4", "no break after short fe", brk, 0);
    send(8'h11, 0, 1, 1);

    // R5 tags follow the head entry
    mon_credit = 0;
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h81, 0, 1, 1);
    send(8'h81, 1, 1, 1);
    send(8'h10, 0, 0, 1);
    chk("R5", "head parity clean", par_err, 0);
    chk("R5", "head framing clean", frm_err, 0);
    chk("R6", "rdy with entries", rdy, 1);
    step_pop();
    chk("R5", "second parity tag", par_err, 1);
    chk("R5", "second framing tag", frm_err, 0);
    step_pop();
    chk("R5", "third framing tag", frm_err, 1);
    chk("R5", "third parity tag", par_err, 0);
    step_pop();
    chk("R6", "rdy empty", rdy, 0);
    chk("R5", "framing when empty", frm_err, 0);
    chk("R5", "parity when empty", par_err, 0);
    par_en = 1'b0;
    mon_credit = -1;

    // R7/R8 break
    expq.push_back({1'b1, 1'b0, 8'h00});
    @(negedge clk); rx = 1'b0;
    repeat (20 * BIT) @(negedge clk);
    chk("R7", "break flag", brk, 1);
    chk("R7", "break frame consumed", expq.size(), 0);
    chk("R8", "nothing during break", rdy, 0);
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    send(8'h3C, 0, 1, 1);

    // R9 clear protocol
    st_write(2'b10);
    @(negedge clk);
    chk("R9", "write0 without read", brk, 1);
    st_read();
    st_write(2'b11);
    @(negedge clk);
    chk("R9", "write1 after read", brk, 1);
    st_write(2'b10);
    @(negedge clk);
    chk("R9", "write0 after disarm", brk, 1);
    st_read();
    st_write(2'b10);
    @(negedge clk);
    chk("R9", "read then write0 clears", brk, 0);

    // R10 overrun
    mon_credit = 0;
    for (int k = 0; k < 16; k++) send(8'(k * 7 + 1), 0, 1, 1);
    chk("R10", "no overrun at 16", ovr, 0);
    send(8'hEE, 0, 1, 0);
    chk("R10", "overrun set", ovr, 1);
    chk("R10", "head is oldest", rd_data, 8'h01);
    mon_credit = -1;
    repeat (60) @(negedge clk);
    chk("R10", "dropped byte absent", expq.size(), 0);
    chk("R10", "queue empty", rdy, 0);
    st_read();
    st_write(2'b01);
    @(negedge clk);
    chk("R10", "overrun cleared", ovr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule